// File: doc/BRIEF.md
# Multiplierless Transposed FIR Filter

This block is a fixed-coefficient FIR filter with all taps computed in parallel, built in transposed form. Each accepted input sample goes to every tap in the same clock. No hardware multiplier is used. Each coefficient is split into a sign, a power-of-two shift and an odd "fundamental". Every distinct fundamental is built once from the sample, using shifts and additions or subtractions chosen by its canonical signed-digit form. Taps whose coefficients share an odd part reuse that one term.

The tap products feed a chain of registered adders. Each adder adds one product to the partial sum handed up from the tap behind it. The longest path is therefore the constant-multiply network plus one adder, whatever the tap count. The result is kept at full precision, with no rounding or saturation. A sample is accepted on any clock where the valid input is high. When valid is low the filter freezes, so gaps in the input stream do not disturb the result.

Top module: `fir_shiftadd_top`

## Requirements
- R1: Each accepted sample x[n] produces out_sample = sum over k of h[k]*x[n-k], where only accepted samples count. Coefficient h[k] is the two's-complement field COEFS[k*COEF_W +: COEF_W], and k = 0 weights the newest sample. The result is registered, so it appears on the clock edge that accepts x[n].
- R2: out_valid is high in exactly the cycle after a clock edge that saw in_valid high outside reset. It is low otherwise.
- R3: On a clock with in_valid low, no chain register advances and out_sample keeps its previous value. Later outputs equal the R1 result computed with the gap removed.
- R4: Synchronous active-high reset clears out_valid, out_sample and every chain register to zero. Samples accepted before reset have no effect on outputs after it.
- R5: out_sample is IN_W + COEF_W + ceil(log2(TAPS)) bits wide and exact. This includes an input of -2^(IN_W-1) and a coefficient of -2^(COEF_W-1).
- R6: Coefficient products use only shifts, additions and subtractions. Taps with an equal odd part share one term. Each product fits in IN_W + COEF_W signed bits. For a positive input it has the sign of its coefficient, and a zero input gives zero products.
- R7: The default set is 3, -5, 11, 23, 11, -5, 3 over 7 taps. A 4-tap set of 7, -128, 1, 0 (h[0] first) is also supported, including its zero and most-negative coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accepted on this clock when high |
| in_sample | input | IN_W | Signed two's-complement input sample |
| out_valid | output | 1 | out_sample holds a new result |
| out_sample | output | IN_W+COEF_W+ceil(log2(TAPS)) | Signed full-precision filter output |

## Verification
Every cycle, the assertions check the following:
- the one-cycle valid relation and the freeze of the output and chain while valid is low;
- the cleared state after reset;
- that each tap product stays within its signed width, follows its coefficient's sign and vanishes for a zero sample.

The assertions cannot show that the values are correct. Only the bench's scenarios show this, by comparing against a direct-form convolution. The scenarios are an impulse that reads back the coefficients in order, a step, random streams with gaps, extreme input values, and a reset in the middle of a stream. They run on both the 7-tap and 4-tap sets.

// File: rtl/fir_sa_pkg.sv
package fir_sa_pkg;

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // number of trailing zero bits of |v| (0 for v == 0)
  function automatic int tz_count(input int v);
    int t;
    int n;
    t = abs_i(v);
    n = 0;
    for (int i = 0; i < 31; i++) begin
      if (t != 0 && (t % 2) == 0) begin
        t = t / 2;
        n++;
      end
    end
    return n;
  endfunction

  // odd fundamental of a coefficient: |v| with trailing zeros removed
  function automatic int odd_part(input int v);
    return abs_i(v) >> tz_count(v);
  endfunction

  // canonical signed digit of non-negative v at bit position pos: -1, 0 or +1
  function automatic int csd_digit(input int v, input int pos);
    int t;
    int d;
    int r;
    t = v;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((t % 2) != 0) begin
        d = ((t % 4) == 3) ? -1 : 1;
        t = t - d;
      end else begin
        d = 0;
      end
      if (i == pos) r = d;
      t = t / 2;
    end
    return r;
  endfunction

  function automatic int acc_width(input int in_w, input int coef_w, input int taps);
    return in_w + coef_w + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir_csd_const.sv
// Multiplies a signed sample by one positive odd constant using only
// shifted additions and subtractions chosen by the constant's CSD digits.
module fir_csd_const
  import fir_sa_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 23,
  parameter int K     = 1,
  parameter int SPAN  = 9
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] p_o
);

  logic signed [OUT_W-1:0] x_ext;
  logic signed [OUT_W-1:0] part [SPAN+1];

  assign x_ext   = {{(OUT_W-IN_W){x_i[IN_W-1]}}, x_i};
  assign part[0] = '0;

  for (genvar b = 0; b < SPAN; b++) begin : g_dig
    localparam int D = csd_digit(K, b);
    if (D == 1) begin : g_add
      assign part[b+1] = part[b] + (x_ext <<< b);
    end else if (D == -1) begin : g_sub
      assign part[b+1] = part[b] - (x_ext <<< b);
    end else begin : g_pass
      assign part[b+1] = part[b];
    end
  end

  assign p_o = part[SPAN];

endmodule

// File: rtl/fir_mcm_bank.sv
// Shared constant-multiplication block: one shift-add term per distinct
// odd fundamental, reused by every tap whose coefficient reduces to it.
module fir_mcm_bank
  import fir_sa_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int COEF_W = 8,
  parameter int TAPS   = 7,
  parameter int ACC_W  = 23,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic signed [IN_W-1:0]  x_i,
  output logic [TAPS*ACC_W-1:0]   prod_o
);

  localparam int PROD_W = IN_W + COEF_W;

  function automatic int coef_at(input int k);
    return int'($signed(COEFS[k*COEF_W +: COEF_W]));
  endfunction

  // first tap whose coefficient has the same odd fundamental as tap k
  function automatic int leader(input int k);
    int r;
    bit found;
    r = k;
    found = 1'b0;
    for (int j = 0; j < TAPS; j++) begin
      if (j < k && !found && odd_part(coef_at(j)) == odd_part(coef_at(k))) begin
        r = j;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic signed [ACC_W-1:0] fund [TAPS];
  logic signed [ACC_W-1:0] prod [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int CV  = coef_at(k);
    localparam int ODD = odd_part(CV);
    localparam int SH  = tz_count(CV);
    localparam int LD  = leader(k);

    if (LD == k && ODD != 0) begin : g_fund
      fir_csd_const #(
        .IN_W (IN_W),
        .OUT_W(ACC_W),
        .K    (ODD),
        .SPAN (COEF_W + 1)
      ) u_fund (
        .x_i(x_i),
        .p_o(fund[k])
      );
    end else begin : g_nofund
      assign fund[k] = '0;
    end

    if (ODD == 0) begin : g_zero
      assign prod[k] = '0;
    end else if (CV < 0) begin : g_neg
      assign prod[k] = -(fund[LD] <<< SH);
    end else begin : g_pos
      assign prod[k] = fund[LD] <<< SH;
    end

    assign prod_o[k*ACC_W +: ACC_W] = prod[k];

    // R6: product stays within IN_W+COEF_W signed bits
    a_r6_prod_fits: assert property (@(posedge clk_i) disable iff (rst_i)
      (prod[k][ACC_W-1:PROD_W-1] == '0) || (prod[k][ACC_W-1:PROD_W-1] == '1));

    if (CV != 0) begin : g_sgn
      // R6: positive sample gives a product with the coefficient's sign
      a_r6_prod_sign: assert property (@(posedge clk_i) disable iff (rst_i)
        (x_i > 0) |-> ((prod[k] < 0) == (CV < 0)));
    end
  end

  // R6: a zero sample yields zero on every tap product
  a_r6_zero_in: assert property (@(posedge clk_i) disable iff (rst_i)
    (x_i == '0) |-> (prod_o == '0));

endmodule

// File: rtl/fir_tap_chain.sv
// Transposed accumulation chain: one registered adder per tap boundary,
// plus the registered output adder for tap 0.
module fir_tap_chain #(
  parameter int TAPS  = 7,
  parameter int ACC_W = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    en_i,
  input  logic [TAPS*ACC_W-1:0]   prod_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    vld_o
);

  logic signed [ACC_W-1:0] s_q [TAPS-1];

  for (genvar k = 0; k < TAPS-1; k++) begin : g_stage
    logic signed [ACC_W-1:0] up;
    if (k == TAPS-2) begin : g_last
      assign up = '0;
    end else begin : g_mid
      assign up = s_q[k+1];
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        s_q[k] <= '0;
      end else if (en_i) begin
        s_q[k] <= $signed(prod_i[(k+1)*ACC_W +: ACC_W]) + up;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) begin
        y_o <= $signed(prod_i[0 +: ACC_W]) + s_q[0];
      end
    end
  end

  // R2: valid output exactly one cycle after an accepted sample
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_o == ($past(en_i) && !$past(rst_i)));

  // R3: output word frozen when no sample is accepted
  a_r3_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(y_o));

  // R3: chain frozen when no sample is accepted
  a_r3_chain_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(s_q[0]));

  // R4: reset leaves output, valid and chain head cleared
  a_r4_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (vld_o == 1'b0 && y_o == '0 && s_q[0] == '0));

endmodule

// File: rtl/fir_shiftadd_top.sv
module fir_shiftadd_top
  import fir_sa_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int COEF_W = 8,
  parameter int TAPS   = 7,
  parameter logic [TAPS*COEF_W-1:0] COEFS =
    {8'h03, 8'hFB, 8'h0B, 8'h17, 8'h0B, 8'hFB, 8'h03}
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          in_valid,
  input  logic signed [IN_W-1:0]                        in_sample,
  output logic                                          out_valid,
  output logic signed [IN_W+COEF_W+$clog2(TAPS)-1:0]    out_sample
);

  localparam int ACC_W = acc_width(IN_W, COEF_W, TAPS);

  logic [TAPS*ACC_W-1:0] prod;

  fir_mcm_bank #(
    .IN_W  (IN_W),
    .COEF_W(COEF_W),
    .TAPS  (TAPS),
    .ACC_W (ACC_W),
    .COEFS (COEFS)
  ) u_bank (
    .clk_i (clk),
    .rst_i (rst),
    .x_i   (in_sample),
    .prod_o(prod)
  );

  fir_tap_chain #(
    .TAPS (TAPS),
    .ACC_W(ACC_W)
  ) u_chain (
    .clk_i (clk),
    .rst_i (rst),
    .en_i  (in_valid),
    .prod_i(prod),
    .y_o   (out_sample),
    .vld_o (out_valid)
  );

endmodule

// File: tb/sim_fir_shiftadd_top.sv
module sim_fir_shiftadd_top;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic               v0, v1;
  logic signed [22:0] y0;
  logic signed [21:0] y1;

  int n_checks = 0;
  int n_fails  = 0;

  int     h0 [7] = '{3, -5, 11, 23, 11, -5, 3};
  int     h1 [4] = '{7, -128, 1, 0};
  longint hist0 [7];
  longint hist1 [4];
  longint exp0 = 0;
  longint exp1 = 0;

  always #5 clk = ~clk;

  fir_shiftadd_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v0), .out_sample(y0)
  );

  fir_shiftadd_top #(
    .TAPS(4),
    .COEFS({8'h00, 8'h01, 8'h80, 8'h07})
  ) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v1), .out_sample(y1)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_ref();
    for (int k = 0; k < 7; k++) hist0[k] = 0;
    for (int k = 0; k < 4; k++) hist1[k] = 0;
    exp0 = 0;
    exp1 = 0;
  endtask

  // called at a falling edge: drive, let one rising edge pass, check at next falling edge
  task automatic step(input int x, input bit v, input string req);
    in_valid  = v;
    in_sample = 12'(x);
    if (v) begin
      for (int k = 6; k > 0; k--) hist0[k] = hist0[k-1];
      hist0[0] = x;
      for (int k = 3; k > 0; k--) hist1[k] = hist1[k-1];
      hist1[0] = x;
      exp0 = 0;
      for (int k = 0; k < 7; k++) exp0 += h0[k] * hist0[k];
      exp1 = 0;
      for (int k = 0; k < 4; k++) exp1 += h1[k] * hist1[k];
    end
    @(negedge clk);
    check("R2", "u0 valid", longint'(v0), longint'(v));
    check("R2", "u1 valid", longint'(v1), longint'(v));
    check(req, "u0 sample", longint'(y0), exp0);
    check({req, "/R7"}, "u1 sample", longint'(y1), exp1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_ref();
    check("R4", "u0 valid after reset", longint'(v0), 0);
    check("R4", "u0 sample after reset", longint'(y0), 0);
    check("R4", "u1 sample after reset", longint'(y1), 0);
  endtask

  // R1 R6 R7: impulse reads the coefficients back in tap order
  task automatic test_impulse();
    step(1, 1'b1, "R1");
    for (int i = 0; i < 8; i++) step(0, 1'b1, "R6");
  endtask

  task automatic test_step();
    for (int i = 0; i < 10; i++) step(100, 1'b1, "R1");
  endtask

  // R3: gaps hold the output and do not shift the history
  task automatic test_gaps();
    for (int i = 0; i < 40; i++) begin
      logic signed [11:0] r;
      r = 12'($urandom);
      step(int'(r), (i % 3) != 1, "R3");
    end
  endtask

  // R5: extreme input values, also against the -128 coefficient
  task automatic test_extremes();
    for (int i = 0; i < 8; i++) step(-2048, 1'b1, "R5");
    for (int i = 0; i < 8; i++) step((i % 2) ? 2047 : -2048, 1'b1, "R5");
  endtask

  task automatic test_random();
    for (int i = 0; i < 200; i++) begin
      logic signed [11:0] r;
      r = 12'($urandom);
      step(int'(r), ($urandom % 4) != 0, "R1");
    end
  endtask

  // R4: history before a mid-stream reset is forgotten
  task automatic test_midreset();
    for (int i = 0; i < 5; i++) step(1500 - 700 * i, 1'b1, "R1");
    do_reset();
    step(1, 1'b1, "R4");
    for (int i = 0; i < 7; i++) step(0, 1'b1, "R4");
  endtask

  initial begin
    clear_ref();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    do_reset();
    test_impulse();
    test_step();
    test_gaps();
    test_extremes();
    test_random();
    test_midreset();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule